// File: doc/BRIEF.md
# Chip-Select Command Unit with Per-Pin Polarity

This block sits in a serial-peripheral controller and owns the chip-select pins. It takes 16-bit commands over a valid/ready handshake. A 3-bit opcode in bits 14:12 selects the command. Only two opcodes do anything here: a chip-select update and a polarity-mask load. Every other opcode is accepted in one cycle and dropped.

Chip-select commands are written in logical terms. A 0 bit in the low byte always means "this pin is selected", whatever the pin's electrical polarity. The per-pin polarity mask is applied by XOR only where the output register loads. A set mask bit turns that pin into an active-high select.

Each chip-select update is wrapped in a pause before and after the register load. The pause length is the command's 2-bit delay field times (prescaler + 1) clock cycles. The 8-bit prescaler is loaded through a sideband write port.

Top module: `cs_cmd_unit`

## Requirements
- R1: After reset, `cs_o` is 8'hFF and `cmd_ready_o` is high.
- R2: The polarity mask resets to 8'h00, so a first chip-select command with low byte 8'hFE drives `cs_o` to 8'hFE.
- R3: A chip-select command (bits 14:12 = 3'b001) loads `cs_o` with the command's bits 7:0 XOR the current polarity mask.
- R4: A mask command (bits 14:12 = 3'b100) loads the mask from bits 7:0 in its acceptance cycle and leaves `cs_o` unchanged until the next chip-select command.
- R5: Any other opcode (3'b000, 3'b010, 3'b011, 3'b101, 3'b110, 3'b111) is accepted with `cmd_ready_o` staying high, and it changes neither `cs_o` nor the mask.
- R6: Let the command be accepted at clock edge E, and let N = bits 9:8 × (prescaler + 1). Then `cs_o` takes its new value at edge E+N+1 and holds its old value before that edge.
- R7: `cmd_ready_o` falls after the accepting edge of a chip-select command and rises again at edge E+2N+1.
- R8: When `presc_we_i` is high at a clock edge, the prescaler is loaded from `presc_data_i`. The prescaler resets to 0.
- R9: With low byte 8'hFE, a mask of 8'hFF gives `cs_o` = 8'h01, a mask of 8'h00 gives 8'hFE, and a mask of 8'h01 gives 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_data_i | input | 16 | Command word |
| cmd_ready_o | output | 1 | Unit can accept a command |
| presc_we_i | input | 1 | Prescaler write enable |
| presc_data_i | input | 8 | Prescaler write value |
| cs_o | output | 8 | Chip-select pins |

## Verification
The bench builds the unit with its default widths: 8 select pins, an 8-bit prescaler and a 2-bit delay field.

The full 8-bit prescaler is reachable at this size. A prescaler of 255 with delay 1 gives a 256-cycle pause on each side of the update, which stretches the pause counter across its carry boundaries. Zero, short and mid-length pauses are also covered, so the exact edge of every select change and every ready return is compared against the delay formula. All three documented mask cases are exercised.

// File: rtl/cs_cmd_pkg.sv
package cs_cmd_pkg;
  localparam int CMD_W = 16;
  localparam int OP_LSB = 12;
  localparam int DLY_LSB = 8;

  typedef enum logic [2:0] {
    OP_XFER  = 3'b000,
    OP_CS    = 3'b001,
    OP_CFG   = 3'b010,
    OP_MISC  = 3'b011,
    OP_CSPOL = 3'b100
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_UPD,
    ST_POST
  } seq_state_e;
endpackage

// File: rtl/cs_cmd_decode.sv
module cs_cmd_decode
  import cs_cmd_pkg::*;
#(
  parameter int CS_W  = 8,
  parameter int DLY_W = 2
) (
  input  logic [CMD_W-1:0] cmd_i,
  output logic             is_cs_o,
  output logic             is_pol_o,
  output logic [CS_W-1:0]  bits_o,
  output logic [DLY_W-1:0] dly_o
);
  opcode_e op;

  always_comb begin
    op       = opcode_e'(cmd_i[OP_LSB+2:OP_LSB]);
    is_cs_o  = (op == OP_CS);
    is_pol_o = (op == OP_CSPOL);
    bits_o   = cmd_i[CS_W-1:0];
    dly_o    = cmd_i[DLY_LSB+DLY_W-1:DLY_LSB];
  end
endmodule

// File: rtl/cs_delay_timer.sv
module cs_delay_timer #(
  parameter int DLY_W = 2,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DLY_W-1:0] steps_i,
  input  logic [DIV_W-1:0] presc_i,
  output logic             done_o
);
  localparam int TOT_W = DLY_W + DIV_W;

  logic [TOT_W-1:0] total, cnt_q;

  // steps * (presc + 1) always fits in DLY_W + DIV_W bits
  always_comb begin
    total  = TOT_W'(TOT_W'(steps_i) * (TOT_W'(presc_i) + TOT_W'(1)));
    done_o = (cnt_q == total - TOT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + TOT_W'(1);
  end
endmodule

// File: rtl/cs_pol_out.sv
module cs_pol_out #(
  parameter int CS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pol_we_i,
  input  logic [CS_W-1:0] pol_i,
  input  logic            upd_i,
  input  logic [CS_W-1:0] bits_i,
  output logic [CS_W-1:0] cs_o
);
  logic [CS_W-1:0] mask_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (pol_we_i) mask_q <= pol_i;
  end

  // polarity applied only at load; a new mask waits for the next update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cs_q <= '1;
    else if (upd_i) cs_q <= bits_i ^ mask_q;
  end

  assign cs_o = cs_q;
endmodule

// File: rtl/cs_cmd_unit.sv
module cs_cmd_unit
  import cs_cmd_pkg::*;
#(
  parameter int CS_W  = 8,
  parameter int DIV_W = 8,
  parameter int DLY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_data_i,
  output logic             cmd_ready_o,
  input  logic             presc_we_i,
  input  logic [DIV_W-1:0] presc_data_i,
  output logic [CS_W-1:0]  cs_o
);
  seq_state_e       state_q, state_d;
  logic [CS_W-1:0]  bits_q, dec_bits;
  logic [DLY_W-1:0] dly_q, dec_dly;
  logic [DIV_W-1:0] presc_q;
  logic             dec_cs, dec_pol, accept, tmr_done, tmr_clr;

  cs_cmd_decode #(.CS_W(CS_W), .DLY_W(DLY_W)) dec_i (
    .cmd_i   (cmd_data_i),
    .is_cs_o (dec_cs),
    .is_pol_o(dec_pol),
    .bits_o  (dec_bits),
    .dly_o   (dec_dly)
  );

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         presc_q <= '0;
    else if (presc_we_i) presc_q <= presc_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '1;
      dly_q  <= '0;
    end else if (accept && dec_cs) begin
      bits_q <= dec_bits;
      dly_q  <= dec_dly;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept && dec_cs) state_d = (dec_dly != '0) ? ST_PRE : ST_UPD;
      ST_PRE:  if (tmr_done) state_d = ST_UPD;
      ST_UPD:  state_d = (dly_q != '0) ? ST_POST : ST_IDLE;
      ST_POST: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign tmr_clr = !(state_q == ST_PRE || state_q == ST_POST) || tmr_done;

  cs_delay_timer #(.DLY_W(DLY_W), .DIV_W(DIV_W)) tmr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .steps_i(dly_q),
    .presc_i(presc_q),
    .done_o (tmr_done)
  );

  cs_pol_out #(.CS_W(CS_W)) out_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pol_we_i(accept && dec_pol),
    .pol_i   (dec_bits),
    .upd_i   (state_q == ST_UPD),
    .bits_i  (bits_q),
    .cs_o    (cs_o)
  );
endmodule

// File: rtl/cs_cmd_unit_chk.sv
module cs_cmd_unit_chk #(
  parameter int CS_W  = 8,
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [15:0]      cmd_data_i,
  input logic             cmd_ready_o,
  input logic             presc_we_i,
  input logic [DIV_W-1:0] presc_data_i,
  input logic [CS_W-1:0]  cs_o
);
  logic acc_cs, acc_other;
  assign acc_cs    = cmd_valid_i && cmd_ready_o && (cmd_data_i[14:12] == 3'b001);
  assign acc_other = cmd_valid_i && cmd_ready_o && (cmd_data_i[14:12] != 3'b001);

  // R7
  cs_busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_cs |=> !cmd_ready_o);

  // R5
  other_keeps_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_other |=> cmd_ready_o);

  // R5
  other_keeps_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_other |=> $stable(cs_o));

  // R3
  idle_pins_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && $past(cmd_ready_o)) |-> $stable(cs_o));
endmodule

bind cs_cmd_unit cs_cmd_unit_chk #(.CS_W(CS_W), .DIV_W(DIV_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_data_i  (cmd_data_i),
  .cmd_ready_o (cmd_ready_o),
  .presc_we_i  (presc_we_i),
  .presc_data_i(presc_data_i),
  .cs_o        (cs_o)
);

// File: tb/cs_cmd_unit_tb_top.sv
`timescale 1ns/1ps
module cs_cmd_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_data = '0;
  logic        cmd_ready;
  logic        presc_we = 1'b0;
  logic [7:0]  presc_data = '0;
  logic [7:0]  cs;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  int presc_m = 0;
  logic [7:0] mask_m = 8'h00;
  logic [7:0] exp_cs = 8'hFF;

  typedef struct {
    int         at;
    logic [7:0] val;
    string      req;
  } item_t;
  item_t sb_q[$];

  cs_cmd_unit dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_data_i  (cmd_data),
    .cmd_ready_o (cmd_ready),
    .presc_we_i  (presc_we),
    .presc_data_i(presc_data),
    .cs_o        (cs)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h cyc=%0d", req, act, exp, cyc);
    end
  endtask

  // monitor: pops scoreboard items when their cycle arrives
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      if (sb_q[0].at == cyc) begin
        chk(cs == sb_q[0].val, sb_q[0].req, cs, sb_q[0].val);
        void'(sb_q.pop_front());
      end else if (sb_q[0].at < cyc) begin
        chk(1'b0, sb_q[0].req, cyc, sb_q[0].at);
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic set_presc(input logic [7:0] v);
    @(negedge clk);
    presc_we = 1'b1; presc_data = v;
    @(negedge clk);
    presc_we = 1'b0;
    presc_m = int'(v);
  endtask

  // driver: predicts results and pushes them before the accepting edge
  task automatic send(input logic [15:0] cmd, input string tag);
    int c, n;
    logic [2:0] op;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    c  = cyc;
    op = cmd[14:12];
    n  = 0;
    if (op == 3'b001) begin
      n = int'(cmd[9:8]) * (presc_m + 1);
      sb_q.push_back('{c + n + 1, exp_cs, "R6"});
      exp_cs = cmd[7:0] ^ mask_m;
      sb_q.push_back('{c + n + 2, exp_cs, tag});
    end else begin
      if (op == 3'b100) mask_m = cmd[7:0];
      sb_q.push_back('{c + 2, exp_cs, tag});
    end
    cmd_valid = 1'b1; cmd_data = cmd;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 3'b001) begin
      while (!cmd_ready) @(negedge clk);
      chk(cyc == c + 2*n + 2, "R7", cyc - c, 2*n + 2);
    end else begin
      chk(cmd_ready == 1'b1, "R5", cmd_ready, 1);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs == 8'hFF, "R1", cs, 8'hFF);
    chk(cmd_ready == 1'b1, "R1", cmd_ready, 1);

    send(16'h10FE, "R2");
    send(16'h10FF, "R3");
    send(16'h40FF, "R4");
    send(16'h10FE, "R9");
    send(16'h4000, "R4");
    send(16'h10FE, "R9");
    send(16'h4001, "R4");
    send(16'h10FE, "R9");

    send(16'h01FE, "R5");
    send(16'h2355, "R5");
    send(16'h33FF, "R5");
    send(16'h50AA, "R5");
    send(16'h6000, "R5");
    send(16'h70FE, "R5");
    send(16'h107F, "R5");

    set_presc(8'd3);
    send(16'h12F0, "R8");
    set_presc(8'd0);
    send(16'h133C, "R6");
    set_presc(8'd255);
    send(16'h11AA, "R6");

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R3", sb_q.size(), 0);
    finish_run();
  end
endmodule